// File: doc/BRIEF.md
# Timer input capture channel

One capture channel of a general-purpose timer. Two asynchronous pin inputs, the channel's own pin and the neighbouring channel's pin, are synchronised with two flops each and then debounced by a digital filter. The filter is clocked by a separate sampling enable and only accepts a new level that has held for a programmed number of samples. An edge detector on each filtered pin produces rising and falling pulses. A polarity setting picks which of them counts as the channel's edge.

A source selector chooses what triggers a capture: the own pin edge, the neighbour pin edge, or an internal trigger line. An event prescaler then passes every 1st, 2nd, 4th or 8th selected event. Each passed event copies the free-running counter value into the capture register and raises a capture flag. A capture that lands while the flag is still set also raises an overcapture flag. The own pin's filtered edge is always exported toward a slave-mode controller, whatever the capture setup.

Top module: `tim_capture_chan`

## Requirements
- R1: After reset the capture value is 0, the capture and overcapture flags are 0 and `edge_o` is low.
- R2: With `flt_cfg_i` = 0 the filter is bypassed. A pin change made between clock edges shows as a one-cycle edge pulse in the cycle after the second rising clock edge that follows the change.
- R3: With `flt_cfg_i` = k > 0, the filtered level changes only after the synchronised input has differed from it on k consecutive cycles with `smp_en_i` high. Each such extra sample delays the R2 pulse by one cycle. A shorter excursion produces no edge. Cycles with `smp_en_i` low take no sample.
- R4: `pol_fall_i` = 0 selects rising edges and 1 selects falling edges. `pol_both_i` = 1 makes both edges valid. The same setting applies to the neighbour pin's edges.
- R5: `src_sel_i` = 01 captures on the own pin edge, 10 on the neighbour pin edge, and 11 on a high cycle of `trig_i`. 00 leaves the channel out of input mode: no capture, and the prescaler is held at zero.
- R6: `psc_cfg_i` codes 00, 01, 10, 11 make every 1st, 2nd, 4th or 8th selected event a capture.
- R7: The prescaler count returns to zero when `psc_cfg_i` changes or capture is disabled. An event in that same cycle is dropped. After re-enabling, the first capture needs the full programmed number of events. A change of source does not clear the count.
- R8: A capture stores the `cnt_i` value present in the cycle of the qualifying event into `cap_val_o` and sets `cap_flag_o`.
- R9: A capture while `cap_flag_o` is already set also sets `ovr_flag_o`.
- R10: `flag_clr_i` clears both flags. If a capture falls in the same cycle, the capture wins: `cap_flag_o` stays 1 and `ovr_flag_o` becomes set if `cap_flag_o` was already 1.
- R11: `edge_o` carries the own pin's polarity-selected filtered edge regardless of `cap_en_i` and `src_sel_i`.
- R12: While `cap_en_i` is 0, `cap_val_o` and the flags never take a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Filter sampling enable |
| pin_own_i | input | 1 | This channel's pin, asynchronous |
| pin_nbr_i | input | 1 | Neighbouring channel's pin, asynchronous |
| trig_i | input | 1 | Internal trigger, synchronous |
| cnt_i | input | CNT_W | Free-running counter value |
| flt_cfg_i | input | FLT_W | Filter length in samples, 0 bypasses the filter |
| src_sel_i | input | 2 | Capture source selection |
| psc_cfg_i | input | PSC_W | Event prescale code |
| pol_fall_i | input | 1 | Falling edge select |
| pol_both_i | input | 1 | Both edges valid |
| cap_en_i | input | 1 | Capture enable |
| flag_clr_i | input | 1 | Clear capture and overcapture flags |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Capture occurred |
| ovr_flag_o | output | 1 | Capture occurred while the flag was pending |
| edge_o | output | 1 | Own filtered edge toward the slave-mode controller |

## Verification
The collision of interest is a capture landing in the same cycle as a flag clear. The bench provokes it by raising `trig_i` and `flag_clr_i` on the same falling edge while the capture flag is already pending. It then expects the flag to stay set, the overcapture flag to rise, and the stored value to be the counter value of that cycle. A second collision, a prescale write or a disable meeting a counted event, is judged by how many further events the next capture needs.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_OWN = 2'b01,
    SRC_NBR = 2'b10,
    SRC_TRG = 2'b11
  } cap_src_e;
endpackage

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic             pin_i,
  input  logic [FLT_W-1:0] cfg_i,
  output logic             filt_o
);
  logic [1:0]       sync_q;
  logic             filt_q;
  logic [FLT_W-1:0] rem_q;
  logic             bypass;

  assign bypass = (cfg_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      rem_q  <= '1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (bypass) begin
        filt_q <= sync_q[1];
        rem_q  <= cfg_i;
      end else if (smp_en_i) begin
        // remaining samples before the new level is accepted
        if (sync_q[1] == filt_q) begin
          rem_q <= cfg_i;
        end else if (rem_q <= FLT_W'(1)) begin
          filt_q <= sync_q[1];
          rem_q  <= cfg_i;
        end else begin
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  assign filt_o = bypass ? sync_q[1] : filt_q;
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic pol_fall_i,
  input  logic pol_both_i,
  output logic edge_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= filt_i;
  end

  assign rise = filt_i & ~prev_q;
  assign fall = ~filt_i & prev_q;

  always_comb begin
    if (pol_both_i)      edge_o = rise | fall;
    else if (pol_fall_i) edge_o = fall;
    else                 edge_o = rise;
  end
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             evt_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             fire_o
);
  localparam int MAX_LOG = (1 << PSC_W) - 1;
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] last;
  logic             restart;

  assign last    = ~({CNT_W{1'b1}} << psc_i);
  assign restart = !active_i || (psc_i != psc_q);
  assign fire_o  = evt_i && !restart && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      psc_q <= '0;
    end else begin
      psc_q <= psc_i;
      if (restart)    cnt_q <= '0;
      else if (evt_i) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tim_capture_chan.sv
module tim_capture_chan
  import cap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic             pin_own_i,
  input  logic             pin_nbr_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [FLT_W-1:0] flt_cfg_i,
  input  logic [1:0]       src_sel_i,
  input  logic [PSC_W-1:0] psc_cfg_i,
  input  logic             pol_fall_i,
  input  logic             pol_both_i,
  input  logic             cap_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o,
  output logic             edge_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins, filt, edg;
  cap_src_e        src;
  logic            sel_evt, active, cap_fire;

  assign pins = {pin_nbr_i, pin_own_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    cap_filter #(.FLT_W(FLT_W)) u_flt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .smp_en_i(smp_en_i),
      .pin_i   (pins[g]),
      .cfg_i   (flt_cfg_i),
      .filt_o  (filt[g])
    );
    cap_edge u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .filt_i    (filt[g]),
      .pol_fall_i(pol_fall_i),
      .pol_both_i(pol_both_i),
      .edge_o    (edg[g])
    );
  end

  assign edge_o = edg[0];
  assign src    = cap_src_e'(src_sel_i);
  assign active = cap_en_i && (src != SRC_OFF);

  always_comb begin
    unique case (src)
      SRC_OWN: sel_evt = edg[0];
      SRC_NBR: sel_evt = edg[1];
      SRC_TRG: sel_evt = trig_i;
      default: sel_evt = 1'b0;
    endcase
  end

  cap_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .evt_i   (sel_evt),
    .psc_i   (psc_cfg_i),
    .fire_o  (cap_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_val_o  <= '0;
      cap_flag_o <= 1'b0;
      ovr_flag_o <= 1'b0;
    end else if (cap_fire) begin
      // capture takes priority over a same-cycle clear
      cap_val_o  <= cnt_i;
      cap_flag_o <= 1'b1;
      ovr_flag_o <= ovr_flag_o | cap_flag_o;
    end else if (flag_clr_i) begin
      cap_flag_o <= 1'b0;
      ovr_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tim_capture_chan_chk.sv
module tim_capture_chan_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       src_sel_i,
  input logic [PSC_W-1:0] psc_cfg_i,
  input logic             cap_en_i,
  input logic             flag_clr_i,
  input logic             sel_evt,
  input logic             cap_fire,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o
);
  AST_CAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire |=> cap_flag_o && (cap_val_o == $past(cnt_i))); // R8

  AST_NO_CAP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i || src_sel_i == 2'b00) |=> !$rose(cap_flag_o) && $stable(cap_val_o)); // R12

  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(cap_flag_o) && $past(cap_fire)); // R9

  AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_fire) |=> !cap_flag_o && !ovr_flag_o); // R10

  AST_DIV1_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && src_sel_i != 2'b00 && psc_cfg_i == '0 && $stable(psc_cfg_i) && sel_evt)
      |-> cap_fire); // R6
endmodule

bind tim_capture_chan tim_capture_chan_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_i),
  .src_sel_i (src_sel_i),
  .psc_cfg_i (psc_cfg_i),
  .cap_en_i  (cap_en_i),
  .flag_clr_i(flag_clr_i),
  .sel_evt   (sel_evt),
  .cap_fire  (cap_fire),
  .cap_val_o (cap_val_o),
  .cap_flag_o(cap_flag_o),
  .ovr_flag_o(ovr_flag_o)
);

// File: tb/test_tim_capture_chan.sv
module test_tim_capture_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b1, pin_own = 1'b0, pin_nbr = 1'b0, trig = 1'b0;
  logic [15:0] cnt;
  logic [3:0]  flt = '0;
  logic [1:0]  src = 2'b01, psc = 2'b00;
  logic        pol_fall = 1'b0, pol_both = 1'b0, cap_en = 1'b1, flag_clr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag, ovr_flag, edge_out;

  int unsigned cyc = 0;
  int n_chk = 0, n_err = 0, exp_edges = 0, seen_edges = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;
  assign cnt = cyc[15:0];

  always @(negedge clk) if (rst_n && edge_out) seen_edges++;

  tim_capture_chan i_tim_capture_chan (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .pin_own_i(pin_own),
    .pin_nbr_i(pin_nbr), .trig_i(trig), .cnt_i(cnt), .flt_cfg_i(flt),
    .src_sel_i(src), .psc_cfg_i(psc), .pol_fall_i(pol_fall), .pol_both_i(pol_both),
    .cap_en_i(cap_en), .flag_clr_i(flag_clr), .cap_val_o(cap_val),
    .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag), .edge_o(edge_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit pol_ok(bit new_lvl);
    if (pol_both) return 1'b1;
    return pol_fall ? !new_lvl : new_lvl;
  endfunction

  function automatic logic [15:0] exp_cap(int unsigned c0, int k);
    return 16'(c0 + 2 + k);
  endfunction

  // toggle a pin at a falling edge; returns counter value its edge would capture
  task automatic toggle(int p, output logic [15:0] val);
    bit nl;
    @(negedge clk);
    if (p == 0) begin nl = !pin_own; pin_own = nl; end
    else        begin nl = !pin_nbr; pin_nbr = nl; end
    if (p == 0 && pol_ok(nl)) exp_edges++;
    val = exp_cap(cyc, int'(flt));
  endtask

  task automatic trig_pulse(output logic [15:0] val);
    @(negedge clk);
    trig = 1'b1;
    val = cyc[15:0];
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    int ev_cnt;
    void'($urandom(32'h5eed_0042));
    step(3);
    chk("R1 cap_val", cap_val, 0);
    chk("R1 cap_flag", cap_flag, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
    chk("R1 edge", edge_out, 0);
    rst_n = 1'b1;
    step(4);

    // R2 bypass, rising, own source
    toggle(0, v);
    step(10);
    chk("R2 flag", cap_flag, 1);
    chk("R2 value", cap_val, v);

    // R4 both edges, R9 overcapture on pending flag
    pol_both = 1'b1;
    toggle(0, v);
    step(10);
    chk("R4 falling captured", cap_val, v);
    chk("R9 ovr", ovr_flag, 1);

    // R10 plain clear
    clear_flags();
    chk("R10 flag cleared", cap_flag, 0);
    chk("R10 ovr cleared", ovr_flag, 0);

    // R10 capture collides with clear; R5 trigger source
    src = 2'b11;
    trig_pulse(v);
    step(1);
    chk("R5 trig capture", cap_val, v);
    @(negedge clk);
    trig = 1'b1; flag_clr = 1'b1; v = cyc[15:0];
    @(negedge clk);
    trig = 1'b0; flag_clr = 1'b0;
    chk("R10 collision flag", cap_flag, 1);
    chk("R10 collision ovr", ovr_flag, 1);
    chk("R10 collision value", cap_val, v);
    clear_flags();

    // R3 filter length 4: 3-cycle glitch rejected, then sustained level accepted
    src = 2'b01; pol_both = 1'b0; pol_fall = 1'b0; flt = 4'd4;
    step(3);
    @(negedge clk); pin_own = 1'b1;
    step(3);
    pin_own = 1'b0;
    step(12);
    chk("R3 glitch rejected", cap_flag, 0);
    toggle(0, v);
    step(14);
    chk("R3 filtered flag", cap_flag, 1);
    chk("R3 filtered value", cap_val, v);
    clear_flags();

    // R3 no samples while smp_en low
    flt = 4'd2; pol_both = 1'b1; smp_en = 1'b0;
    toggle(0, v);
    step(12);
    chk("R3 no sampling", cap_flag, 0);
    smp_en = 1'b1;
    step(8);
    chk("R3 resumed sampling", cap_flag, 1);
    clear_flags();

    // R5 code 00 and R12 disable: no capture, edge still exported (R11)
    flt = '0;
    src = 2'b00;
    toggle(0, v);
    step(10);
    chk("R5 off no capture", cap_flag, 0);
    src = 2'b01; cap_en = 1'b0;
    toggle(0, v);
    step(10);
    chk("R12 disabled no capture", cap_flag, 0);
    chk("R11 edges while not capturing", seen_edges, exp_edges);
    cap_en = 1'b1;

    // R7 prescaler restart on disable: div 8
    src = 2'b11; psc = 2'b11;
    step(2);
    repeat (3) begin trig_pulse(v); step(1); end
    @(negedge clk); cap_en = 1'b0;
    @(negedge clk); cap_en = 1'b1;
    repeat (7) begin trig_pulse(v); step(1); end
    chk("R7 no capture after 7", cap_flag, 0);
    trig_pulse(v);
    step(1);
    chk("R7 capture on 8th", cap_flag, 1);
    chk("R7 value", cap_val, v);
    clear_flags();

    // random mix over own/neighbour source, polarity, prescale, filter
    ev_cnt = 0;
    pol_both = 1'b0;
    for (int it = 0; it < 60; it++) begin
      logic [1:0] nsrc, npsc;
      int pm, p;
      bit nl, evt, fire;
      nsrc = 2'($urandom_range(1, 2));
      npsc = 2'($urandom_range(0, 3));
      pm = $urandom_range(0, 2);
      p = $urandom_range(0, 1);
      if (npsc != psc) ev_cnt = 0;
      @(negedge clk);
      src = nsrc; psc = npsc;
      pol_fall = (pm == 1); pol_both = (pm == 2);
      flt = 4'($urandom_range(0, 6));
      step(3);
      nl = (p == 0) ? !pin_own : !pin_nbr;
      evt = ((p == 0 && src == 2'b01) || (p == 1 && src == 2'b10)) && pol_ok(nl);
      fire = 1'b0;
      if (evt) begin
        ev_cnt++;
        if (ev_cnt == (1 << psc)) begin fire = 1'b1; ev_cnt = 0; end
      end
      toggle(p, v);
      step(12);
      chk("R6 R4 R5 flag", cap_flag, fire);
      if (fire) chk("R8 value", cap_val, v);
      chk("R9 no ovr", ovr_flag, 0);
      clear_flags();
    end

    step(4);
    chk("R11 edge count", seen_edges, exp_edges);
    summary();
  end
endmodule